// File: doc/BRIEF.md
# Control-Endpoint SETUP Packet Receiver with Descriptor Ring

This block takes the SETUP data stage of a control endpoint and lays it down in a small ring of receive descriptors. Each descriptor has four fields: an empty flag, an interrupt-enable flag, a received-byte count and a three-bit status. Each descriptor also owns a fixed-size slice of a byte buffer.

The block takes the following inputs:
- an already-decoded SETUP token strobe;
- a flag that says the endpoint is a control endpoint;
- a byte stream with a valid strobe;
- an end-of-packet strobe, which carries CRC-error and bit-stuff-error flags.

The PID byte is stored first, followed by the payload. When a slice fills, that descriptor is closed and the packet spills into the next descriptor of the ring. At the end of the packet the block asks for an ACK or for silence. A local arm port returns descriptors to the empty state. A read port shows each descriptor and each buffer byte.

The controller has five states:
- **IDLE** waits for a token. IDLE → RECV when the token is accepted and the current descriptor is empty. IDLE → DISCARD when the token is accepted but that descriptor is full.
- **RECV** stores bytes. RECV → FULL when the slice fills. RECV → IDLE at end of packet.
- **FULL** holds a closed, full descriptor. FULL → RECV when a further byte finds the next descriptor empty. FULL → OVERRUN when the next descriptor is not empty. FULL → IDLE at end of packet.
- **OVERRUN** drops the rest of the packet. OVERRUN → IDLE at end of packet.
- **DISCARD** drops a packet that had no free descriptor at token time. DISCARD → IDLE at end of packet.

Top module: `setup_rx_ring`

## Requirements
- R1: After reset every descriptor reads as not empty, with count 0, status 0 and interrupt enable 0. The outputs `hs_ack`, `hs_silent`, `irq` and `busy` are low. The ring pointer is at descriptor 0.
- R2: A SETUP token that arrives while `ep_is_ctrl` is low is ignored. No pulse follows, no byte is stored, and the current descriptor stays empty.
- R3: After an accepted token on an empty descriptor, every byte of the packet is stored in arrival order, starting with the PID byte. Byte k of descriptor d lands at buffer address d*BUF_LEN+k.
- R4: The byte that fills a slice closes its descriptor: empty is cleared and the count becomes BUF_LEN. `irq` pulses in the following cycle if and only if that descriptor's interrupt enable is set.
- R5: A byte that arrives after a descriptor filled is stored at offset 0 of the next descriptor, if that descriptor is empty. The next descriptor after index NUM_DESC-1 is index 0.
- R6: At end of packet, a partly filled descriptor is closed with its byte count and raises `irq` if enabled. The ring pointer moves to the next descriptor. If the packet has neither error, `hs_ack` pulses in the cycle after `rx_eop`.
- R7: If `crc_err` or `stuff_err` is high with `rx_eop`, then `hs_silent` pulses instead of `hs_ack`. The error is recorded only in the last descriptor the packet used: status bit 0 is the CRC error and bit 1 is the bit-stuff error.
- R8: A byte that needs the next descriptor when that descriptor is not empty is dropped, and so is the rest of the packet. At end of packet, status bit 2 (overrun) is set in the last descriptor used and `hs_silent` pulses. The descriptor that was not empty is left untouched.
- R9: A token accepted while the current descriptor is not empty gives a one-cycle `busy` pulse in the next cycle. The packet is discarded, `hs_silent` pulses after its end, and the ring pointer does not move.
- R10: An arm write marks the selected descriptor empty, loads its interrupt enable, and clears its count and status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_setup | input | 1 | Decoded SETUP token strobe |
| ep_is_ctrl | input | 1 | Endpoint is configured as control |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_eop | input | 1 | End-of-packet strobe, never with rx_valid |
| crc_err | input | 1 | CRC error, valid with rx_eop |
| stuff_err | input | 1 | Bit-stuff error, valid with rx_eop |
| arm_we | input | 1 | Arm a descriptor |
| arm_idx | input | IDX_W | Descriptor to arm |
| arm_ie | input | 1 | Interrupt enable loaded on arm |
| rd_idx | input | IDX_W | Descriptor selected for readout |
| rd_empty | output | 1 | Empty flag of selected descriptor |
| rd_irq_en | output | 1 | Interrupt enable of selected descriptor |
| rd_count | output | CNT_W | Byte count of selected descriptor |
| rd_status | output | 3 | Status {overrun, stuff, crc} of selected descriptor |
| rd_addr | input | ADDR_W | Buffer byte address for readout |
| rd_data | output | 8 | Buffer byte at rd_addr |
| hs_ack | output | 1 | Request ACK handshake (pulse) |
| hs_silent | output | 1 | Request no handshake (pulse) |
| irq | output | 1 | Interrupt pulse |
| busy | output | 1 | No free descriptor at token time (pulse) |

## Verification
The bench builds the ring with NUM_DESC=4 and BUF_LEN=4. A slice this short lets packets of five to ten bytes reach a fill, a spill into the next descriptor, a wrap from index 3 back to 0, and an overrun within a few dozen cycles. With only four descriptors, a few packets use up the whole ring, which exercises the busy discard and a packet that ends exactly on a slice boundary.

// File: rtl/setup_rx_pkg.sv
`timescale 1ns/1ps
package setup_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_FULL,
        ST_OVERRUN,
        ST_DISCARD
    } rx_state_e;

    typedef struct packed {
        logic overrun;
        logic stuff;
        logic crc;
    } rx_status_t;

endpackage

// File: rtl/desc_ring_table.sv
`timescale 1ns/1ps
module desc_ring_table
    import setup_rx_pkg::*;
#(
    parameter int NUM_DESC = 4,
    parameter int IDX_W    = 2,
    parameter int CNT_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arm_we,
    input  logic [IDX_W-1:0]     arm_idx,
    input  logic                 arm_ie,
    input  logic                 close_we,
    input  logic [IDX_W-1:0]     close_idx,
    input  logic [CNT_W-1:0]     close_cnt,
    input  logic                 stat_we,
    input  logic [IDX_W-1:0]     stat_idx,
    input  rx_status_t           stat_val,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [NUM_DESC-1:0]  empty_vec,
    output logic [NUM_DESC-1:0]  ie_vec,
    output logic                 rd_empty,
    output logic                 rd_ie,
    output logic [CNT_W-1:0]     rd_cnt,
    output rx_status_t           rd_stat
);

    logic [CNT_W-1:0] cnt_arr  [NUM_DESC];
    rx_status_t       stat_arr [NUM_DESC];

    for (genvar i = 0; i < NUM_DESC; i++) begin : g_desc
        localparam logic [IDX_W-1:0] MY = IDX_W'(i);
        logic             e_q;
        logic             ie_q;
        logic [CNT_W-1:0] c_q;
        rx_status_t       s_q;
        logic             hit_close;
        logic             hit_stat;
        logic             hit_arm;

        assign hit_close = close_we && (close_idx == MY);
        assign hit_stat  = stat_we  && (stat_idx  == MY);
        assign hit_arm   = arm_we   && (arm_idx   == MY);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_q  <= 1'b0;
                ie_q <= 1'b0;
                c_q  <= '0;
                s_q  <= '0;
            end else if (hit_arm && !hit_close && !hit_stat) begin
                e_q  <= 1'b1;
                ie_q <= arm_ie;
                c_q  <= '0;
                s_q  <= '0;
            end else begin
                if (hit_close) begin
                    e_q <= 1'b0;
                    c_q <= close_cnt;
                end
                if (hit_stat) begin
                    s_q <= stat_val;
                end
            end
        end

        assign empty_vec[i] = e_q;
        assign ie_vec[i]    = ie_q;
        assign cnt_arr[i]   = c_q;
        assign stat_arr[i]  = s_q;
    end

    assign rd_empty = empty_vec[rd_idx];
    assign rd_ie    = ie_vec[rd_idx];
    assign rd_cnt   = cnt_arr[rd_idx];
    assign rd_stat  = stat_arr[rd_idx];

endmodule

// File: rtl/rx_byte_store.sv
`timescale 1ns/1ps
module rx_byte_store #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/setup_rx_ctl.sv
`timescale 1ns/1ps
module setup_rx_ctl
    import setup_rx_pkg::*;
#(
    parameter int NUM_DESC = 4,
    parameter int BUF_LEN  = 8,
    parameter int IDX_W    = 2,
    parameter int CNT_W    = 4,
    parameter int ADDR_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tok_setup,
    input  logic                ep_is_ctrl,
    input  logic                rx_valid,
    input  logic [7:0]          rx_byte,
    input  logic                rx_eop,
    input  logic                crc_err,
    input  logic                stuff_err,
    input  logic [NUM_DESC-1:0] empty_vec,
    input  logic [NUM_DESC-1:0] ie_vec,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [7:0]          mem_data,
    output logic                close_we,
    output logic [IDX_W-1:0]    close_idx,
    output logic [CNT_W-1:0]    close_cnt,
    output logic                stat_we,
    output logic [IDX_W-1:0]    stat_idx,
    output rx_status_t          stat_val,
    output logic                hs_ack,
    output logic                hs_silent,
    output logic                irq,
    output logic                busy,
    output rx_state_e           state_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BUF_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BUF_LEN);
    localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(NUM_DESC - 1);

    rx_state_e        state, state_d;
    logic [IDX_W-1:0] cur, cur_d, nxt;
    logic [CNT_W-1:0] cnt, cnt_d;
    logic             ack_d, silent_d, irq_d, busy_d;
    logic             fin;
    rx_status_t       fin_err;
    logic [ADDR_W-1:0] base_cur, base_nxt;

    assign nxt      = (cur == IDX_TOP) ? '0 : cur + IDX_W'(1);
    assign base_cur = ADDR_W'(int'(cur) * BUF_LEN);
    assign base_nxt = ADDR_W'(int'(nxt) * BUF_LEN);
    assign mem_data = rx_byte;
    assign state_o  = state;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur   <= '0;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cur   <= cur_d;
            cnt   <= cnt_d;
        end
    end

    // Next state and descriptor/buffer strobes
    always_comb begin
        state_d   = state;
        cur_d     = cur;
        cnt_d     = cnt;
        mem_we    = 1'b0;
        mem_addr  = base_cur + ADDR_W'(cnt);
        close_we  = 1'b0;
        close_idx = cur;
        close_cnt = cnt;
        stat_we   = 1'b0;
        stat_idx  = cur;
        stat_val  = '0;
        ack_d     = 1'b0;
        silent_d  = 1'b0;
        irq_d     = 1'b0;
        busy_d    = 1'b0;
        fin       = 1'b0;
        fin_err   = '{overrun: 1'b0, stuff: stuff_err, crc: crc_err};

        unique case (state)
            ST_IDLE: begin
                if (tok_setup && ep_is_ctrl) begin
                    if (empty_vec[cur]) begin
                        state_d = ST_RECV;
                        cnt_d   = '0;
                    end else begin
                        busy_d  = 1'b1;
                        state_d = ST_DISCARD;
                    end
                end
            end
            ST_RECV: begin
                if (rx_valid) begin
                    mem_we = 1'b1;
                    cnt_d  = cnt + CNT_W'(1);
                    if (cnt == CNT_LAST) begin
                        close_we  = 1'b1;
                        close_cnt = CNT_FULL;
                        irq_d     = ie_vec[cur];
                        state_d   = ST_FULL;
                    end
                end else if (rx_eop) begin
                    close_we = 1'b1;
                    irq_d    = ie_vec[cur];
                    fin      = 1'b1;
                end
            end
            ST_FULL: begin
                if (rx_valid) begin
                    if (empty_vec[nxt]) begin
                        mem_we   = 1'b1;
                        mem_addr = base_nxt;
                        cur_d    = nxt;
                        cnt_d    = CNT_W'(1);
                        state_d  = ST_RECV;
                    end else begin
                        state_d = ST_OVERRUN;
                    end
                end else if (rx_eop) begin
                    fin = 1'b1;
                end
            end
            ST_OVERRUN: begin
                if (rx_eop) begin
                    fin_err.overrun = 1'b1;
                    fin             = 1'b1;
                end
            end
            ST_DISCARD: begin
                if (rx_eop) begin
                    silent_d = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase

        if (fin) begin
            if (fin_err.overrun || fin_err.stuff || fin_err.crc) begin
                stat_we  = 1'b1;
                stat_val = fin_err;
                silent_d = 1'b1;
            end else begin
                ack_d = 1'b1;
            end
            cur_d   = nxt;
            state_d = ST_IDLE;
        end
    end

    // Registered output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_ack    <= 1'b0;
            hs_silent <= 1'b0;
            irq       <= 1'b0;
            busy      <= 1'b0;
        end else begin
            hs_ack    <= ack_d;
            hs_silent <= silent_d;
            irq       <= irq_d;
            busy      <= busy_d;
        end
    end

endmodule

// File: rtl/setup_rx_ring.sv
`timescale 1ns/1ps
module setup_rx_ring
    import setup_rx_pkg::*;
#(
    parameter  int NUM_DESC = 4,
    parameter  int BUF_LEN  = 8,
    localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
    localparam int CNT_W    = $clog2(BUF_LEN + 1),
    localparam int DEPTH    = NUM_DESC * BUF_LEN,
    localparam int ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_setup,
    input  logic              ep_is_ctrl,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_eop,
    input  logic              crc_err,
    input  logic              stuff_err,
    input  logic              arm_we,
    input  logic [IDX_W-1:0]  arm_idx,
    input  logic              arm_ie,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_empty,
    output logic              rd_irq_en,
    output logic [CNT_W-1:0]  rd_count,
    output logic [2:0]        rd_status,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              hs_ack,
    output logic              hs_silent,
    output logic              irq,
    output logic              busy
);

    logic [NUM_DESC-1:0] empty_vec, ie_vec;
    logic                mem_we;
    logic [ADDR_W-1:0]   mem_addr;
    logic [7:0]          mem_data;
    logic                close_we, stat_we;
    logic [IDX_W-1:0]    close_idx, stat_idx;
    logic [CNT_W-1:0]    close_cnt;
    rx_status_t          stat_val, rd_stat;
    rx_state_e           ctl_state;

    setup_rx_ctl #(
        .NUM_DESC(NUM_DESC), .BUF_LEN(BUF_LEN),
        .IDX_W(IDX_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .tok_setup(tok_setup), .ep_is_ctrl(ep_is_ctrl),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_eop(rx_eop),
        .crc_err(crc_err), .stuff_err(stuff_err),
        .empty_vec(empty_vec), .ie_vec(ie_vec),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .close_we(close_we), .close_idx(close_idx), .close_cnt(close_cnt),
        .stat_we(stat_we), .stat_idx(stat_idx), .stat_val(stat_val),
        .hs_ack(hs_ack), .hs_silent(hs_silent), .irq(irq), .busy(busy),
        .state_o(ctl_state)
    );

    desc_ring_table #(
        .NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_tab (
        .clk(clk), .rst_n(rst_n),
        .arm_we(arm_we), .arm_idx(arm_idx), .arm_ie(arm_ie),
        .close_we(close_we), .close_idx(close_idx), .close_cnt(close_cnt),
        .stat_we(stat_we), .stat_idx(stat_idx), .stat_val(stat_val),
        .rd_idx(rd_idx),
        .empty_vec(empty_vec), .ie_vec(ie_vec),
        .rd_empty(rd_empty), .rd_ie(rd_irq_en), .rd_cnt(rd_count),
        .rd_stat(rd_stat)
    );

    rx_byte_store #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W)
    ) u_buf (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_data),
        .raddr(rd_addr), .rdata(rd_data)
    );

    assign rd_status = rd_stat;

endmodule

// File: rtl/setup_rx_chk.sv
`timescale 1ns/1ps
module setup_rx_chk
    import setup_rx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tok_setup,
    input logic      ep_is_ctrl,
    input logic      rx_valid,
    input logic      rx_eop,
    input logic      crc_err,
    input logic      stuff_err,
    input logic      hs_ack,
    input logic      hs_silent,
    input logic      irq,
    input logic      busy,
    input rx_state_e state
);

    assert_one_handshake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_ack && hs_silent));

    assert_ignore_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && tok_setup && !ep_is_ctrl) |=> (state == ST_IDLE));

    assert_ack_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ack |-> ($past(rx_eop) && !$past(crc_err) && !$past(stuff_err)));

    assert_err_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_eop && (crc_err || stuff_err) && state != ST_IDLE) |=> (hs_silent && !hs_ack));

    assert_busy_token_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $past(tok_setup && ep_is_ctrl));

    assert_busy_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(rx_valid || rx_eop));

endmodule

bind setup_rx_ring setup_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tok_setup(tok_setup), .ep_is_ctrl(ep_is_ctrl),
    .rx_valid(rx_valid), .rx_eop(rx_eop), .crc_err(crc_err), .stuff_err(stuff_err),
    .hs_ack(hs_ack), .hs_silent(hs_silent), .irq(irq), .busy(busy),
    .state(ctl_state)
);

// File: tb/sim_setup_rx_ring.sv
`timescale 1ns/1ps
module sim_setup_rx_ring;

    localparam int N  = 4;
    localparam int L  = 4;
    localparam int IW = 2;
    localparam int CW = 3;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_setup = 0, ep_is_ctrl = 0, rx_valid = 0, rx_eop = 0;
    logic crc_err = 0, stuff_err = 0, arm_we = 0, arm_ie = 0;
    logic [7:0] rx_byte = '0;
    logic [IW-1:0] arm_idx = '0, rd_idx = '0;
    logic [AW-1:0] rd_addr = '0;
    logic rd_empty, rd_irq_en, hs_ack, hs_silent, irq, busy;
    logic [CW-1:0] rd_count;
    logic [2:0] rd_status;
    logic [7:0] rd_data;

    always #5 clk = ~clk;

    setup_rx_ring #(.NUM_DESC(N), .BUF_LEN(L)) u0 (
        .clk(clk), .rst_n(rst_n), .tok_setup(tok_setup), .ep_is_ctrl(ep_is_ctrl),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_eop(rx_eop),
        .crc_err(crc_err), .stuff_err(stuff_err),
        .arm_we(arm_we), .arm_idx(arm_idx), .arm_ie(arm_ie),
        .rd_idx(rd_idx), .rd_empty(rd_empty), .rd_irq_en(rd_irq_en),
        .rd_count(rd_count), .rd_status(rd_status),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .hs_ack(hs_ack), .hs_silent(hs_silent), .irq(irq), .busy(busy)
    );

    int checks = 0;
    int errors = 0;

    // Reference model
    bit         m_empty [N];
    bit         m_ie    [N];
    int         m_cnt   [N];
    int         m_stat  [N];
    logic [7:0] m_mem   [N*L];
    bit         m_wr    [N*L];
    int         m_cur, m_mode, m_fill;
    bit         e_ack, e_sil, e_irq, e_busy;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void finish_pkt(input int err);
        if (err != 0) begin
            m_stat[m_cur] = err;
            e_sil = 1;
        end else begin
            e_ack = 1;
        end
        m_cur  = (m_cur + 1) % N;
        m_mode = 0;
    endfunction

    // mode: 0 idle, 1 storing, 2 slice full, 3 dropping after overrun, 4 discarding
    function automatic void model_edge();
        int er;
        e_ack = 0; e_sil = 0; e_irq = 0; e_busy = 0;
        er = (stuff_err ? 2 : 0) + (crc_err ? 1 : 0);
        if (arm_we) begin
            m_empty[arm_idx] = 1; m_ie[arm_idx] = arm_ie;
            m_cnt[arm_idx] = 0; m_stat[arm_idx] = 0;
        end
        case (m_mode)
            0: if (tok_setup && ep_is_ctrl) begin
                   if (m_empty[m_cur]) begin m_mode = 1; m_fill = 0; end
                   else begin e_busy = 1; m_mode = 4; end
               end
            1: if (rx_valid) begin
                   m_mem[m_cur*L + m_fill] = rx_byte;
                   m_wr[m_cur*L + m_fill] = 1;
                   m_fill++;
                   if (m_fill == L) begin
                       m_empty[m_cur] = 0; m_cnt[m_cur] = L;
                       e_irq = m_ie[m_cur]; m_mode = 2;
                   end
               end else if (rx_eop) begin
                   m_empty[m_cur] = 0; m_cnt[m_cur] = m_fill;
                   e_irq = m_ie[m_cur];
                   finish_pkt(er);
               end
            2: if (rx_valid) begin
                   if (m_empty[(m_cur + 1) % N]) begin
                       m_cur = (m_cur + 1) % N;
                       m_mem[m_cur*L] = rx_byte; m_wr[m_cur*L] = 1;
                       m_fill = 1; m_mode = 1;
                   end else begin
                       m_mode = 3;
                   end
               end else if (rx_eop) begin
                   finish_pkt(er);
               end
            3: if (rx_eop) finish_pkt(er + 4);
            4: if (rx_eop) begin e_sil = 1; m_mode = 0; end
            default: m_mode = 0;
        endcase
    endfunction

    task automatic step();
        model_edge();
        @(posedge clk);
        #1;
        chk(hs_ack === e_ack, "R6 hs_ack", int'(hs_ack), int'(e_ack));
        chk(hs_silent === e_sil, "R7 hs_silent", int'(hs_silent), int'(e_sil));
        chk(irq === e_irq, "R4 irq", int'(irq), int'(e_irq));
        chk(busy === e_busy, "R9 busy", int'(busy), int'(e_busy));
        tok_setup = 0; rx_valid = 0; rx_eop = 0; crc_err = 0; stuff_err = 0; arm_we = 0;
    endtask

    task automatic arm(input int idx, input bit ie);
        arm_we = 1; arm_idx = IW'(idx); arm_ie = ie;
        step();
    endtask

    task automatic packet(input bit ctrl, input int n, input int seed, input bit ce, input bit se);
        ep_is_ctrl = ctrl; tok_setup = 1;
        step();
        for (int k = 0; k < n; k++) begin
            rx_valid = 1;
            rx_byte  = (k == 0) ? 8'hC3 : 8'((seed + k * 7) & 8'hFF);
            step();
        end
        rx_eop = 1; crc_err = ce; stuff_err = se;
        step();
        step();
    endtask

    task automatic check_all(input string req);
        for (int d = 0; d < N; d++) begin
            rd_idx = IW'(d);
            #1;
            chk(rd_empty === m_empty[d], req, int'(rd_empty), int'(m_empty[d]));
            chk(rd_irq_en === m_ie[d], req, int'(rd_irq_en), int'(m_ie[d]));
            chk(int'(rd_count) == m_cnt[d], req, int'(rd_count), m_cnt[d]);
            chk(int'(rd_status) == m_stat[d], req, int'(rd_status), m_stat[d]);
        end
        for (int a = 0; a < N*L; a++) begin
            if (m_wr[a]) begin
                rd_addr = AW'(a);
                #1;
                chk(rd_data === m_mem[a], req, int'(rd_data), int'(m_mem[a]));
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int d = 0; d < N; d++) begin
            m_empty[d] = 0; m_ie[d] = 0; m_cnt[d] = 0; m_stat[d] = 0;
        end
        for (int a = 0; a < N*L; a++) m_wr[a] = 0;
        m_cur = 0; m_mode = 0; m_fill = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        chk(!hs_ack && !hs_silent && !irq && !busy, "R1 pulses", int'(hs_ack | hs_silent | irq | busy), 0);
        check_all("R1");
        // R10: arm all descriptors
        arm(0, 1); arm(1, 0); arm(2, 1); arm(3, 1);
        step();
        check_all("R10");
        // R2: token on a non-control endpoint
        packet(0, 3, 17, 0, 0);
        check_all("R2");
        // R3 / R6: short clean packet into descriptor 0
        packet(1, 3, 40, 0, 0);
        check_all("R3");
        // R5: spill from descriptor 1 into 2
        packet(1, 6, 90, 0, 0);
        check_all("R5");
        // R4 / R7: exact fill of descriptor 3 with a CRC error
        packet(1, 4, 5, 1, 0);
        check_all("R7");
        // R9: descriptor 0 still full, packet discarded
        packet(1, 5, 60, 0, 0);
        check_all("R9");
        // R8: overrun into non-empty descriptor 2, with a stuff error
        arm(0, 0); arm(1, 1);
        packet(1, 9, 120, 0, 1);
        check_all("R8");
        // R5: wrap from descriptor 3 back to 0
        arm(2, 1); arm(3, 0); arm(0, 1);
        packet(1, 10, 200, 0, 0);
        check_all("R5 wrap");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule